// File: doc/BRIEF.md
# Bus Clock-Enable Tree

This block stands in for the bus clock tree of a microcontroller. A single fast root clock runs the whole logic. Every bus domain is represented by a one-cycle enable strobe on that root clock, so there are no derived clocks. The tree has several levels. A system-bus (AHB) divider sits on the root. Under it are two peripheral-bus (APB) dividers, a low-speed one and a high-speed one. Each peripheral bus has a timer-kernel enable that follows a doubling rule. Below the high-speed bus sits an ADC kernel divider. Two fixed taps hang off the system bus: a system-tick reference and an SD-card interface strobe.

Each programmable divider reads a small encoded code. The divider holds its current ratio until the running division period ends, and only then loads the new one. The ratio each domain is running at is reported on a decoded output. Logic in a domain qualifies its flops with that domain's enable. The decoded ratios tell observers what rate each domain is actually running at.

Top module: `busclk_en_tree`

## Requirements
- R1: The AHB code selects the ratio to the root clock. Codes 0000 to 0111 give 1. Codes 1000, 1001, 1010 and 1011 give 2, 4, 8 and 16. Codes 1100, 1101, 1110 and 1111 give 64, 128, 256 and 512; 32 cannot be selected. `en_ahb` pulses once per ratio root cycles, and `ahb_div` reports the ratio in use.
- R2: Each APB code selects that domain's ratio to `en_ahb` pulses. Codes 000 to 011 give 1. Codes 100, 101, 110 and 111 give 2, 4, 8 and 16. The two APB domains are independent, and each reports its ratio on its own `*_div` output.
- R3: A timer enable equals its APB enable when that APB ratio is 1. Otherwise it runs at twice the APB pulse rate, and every APB pulse is also a timer pulse.
- R4: The ADC code selects a ratio to high-speed APB pulses: 00 gives 2, 01 gives 4, 10 gives 6 and 11 gives 8. `adc_div` reports the ratio.
- R5: `en_tick` pulses once per 8 `en_ahb` pulses.
- R6: `en_sd` pulses once per 2 `en_ahb` pulses.
- R7: When the AHB ratio is 1, `en_ahb` is held high. Any divider at ratio 1 passes its parent's enable through unchanged.
- R8: With a ratio above 1, every strobe is one root cycle wide. Every strobe coincides with a strobe of its parent domain.
- R9: A new code takes effect only at the pulse that ends the current period. The gap before that pulse still follows the old ratio, and a `*_div` output changes only in the cycle after its domain's pulse.
- R10: While reset is asserted, all strobes are low and all `*_div` outputs read 1. After release, each domain starts at ratio 1. Its first pulse adopts the configured code, and that first `en_ahb` pulse comes two root cycles after release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Root clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ahb_code | input | 4 | AHB ratio code |
| apb_lo_code | input | 3 | Low-speed APB ratio code |
| apb_hi_code | input | 3 | High-speed APB ratio code |
| adc_code | input | 2 | ADC kernel ratio code |
| en_ahb | output | 1 | AHB domain strobe |
| en_apb_lo | output | 1 | Low-speed APB strobe |
| en_apb_hi | output | 1 | High-speed APB strobe |
| en_tim_lo | output | 1 | Timer kernel strobe, low-speed APB side |
| en_tim_hi | output | 1 | Timer kernel strobe, high-speed APB side |
| en_adc | output | 1 | ADC kernel strobe |
| en_tick | output | 1 | System-tick reference strobe |
| en_sd | output | 1 | SD interface strobe |
| ahb_div | output | 10 | AHB ratio in use |
| apb_lo_div | output | 5 | Low-speed APB ratio in use |
| apb_hi_div | output | 5 | High-speed APB ratio in use |
| adc_div | output | 4 | ADC ratio in use |

## Verification
The bench builds the block with its default parameters: 4-bit AHB codes, 3-bit APB codes and 2-bit ADC codes, with fixed tap ratios of 8 and 2. These bring every legal code of every divider within reach, including the 512 extreme and the skipped 32. Measurement windows are multiples of every period, so pulse counts are exact. Mid-period code changes and the first pulses after reset release are timed cycle by cycle.

// File: rtl/busclk_pkg.sv
package busclk_pkg;

  // AHB code: top bit clear -> 1; else low bits pick 2,4,8,16,64,128,256,512
  function automatic logic [15:0] ahb_ratio_of(input logic [7:0] code, input int cw);
    logic [7:0] low;
    logic [7:0] sh;
    if (!code[cw-1]) return 16'd1;
    low = code & 8'((1 << (cw - 1)) - 1);
    sh  = low + 8'd1;
    if (low >= 8'(1 << (cw - 2))) sh = sh + 8'd1;
    return 16'd1 << sh;
  endfunction

  // APB code: top bit clear -> 1; else powers of two from 2 upward
  function automatic logic [15:0] apb_ratio_of(input logic [7:0] code, input int cw);
    logic [7:0] low;
    if (!code[cw-1]) return 16'd1;
    low = code & 8'((1 << (cw - 1)) - 1);
    return 16'd1 << (low + 8'd1);
  endfunction

  // ADC code: even ratios 2,4,6,...
  function automatic logic [15:0] adc_ratio_of(input logic [7:0] code);
    return 16'({code, 1'b0}) + 16'd2;
  endfunction

endpackage

// File: rtl/ce_divider.sv
module ce_divider #(
  parameter int RW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick_in,
  input  logic [RW-1:0] ratio_req,
  output logic          en_out,
  output logic [RW-1:0] cnt_out,
  output logic [RW-1:0] ratio_out
);
  localparam logic [RW-1:0] ONE = RW'(1);

  logic [RW-1:0] cnt_q, cnt_d;
  logic [RW-1:0] ratio_q, ratio_d;
  logic          at_end;

  assign at_end = (cnt_q == '0);

  always_comb begin
    cnt_d   = cnt_q;
    ratio_d = ratio_q;
    en_out  = tick_in & at_end;
    if (tick_in) begin
      if (at_end) begin
        ratio_d = (ratio_req == '0) ? ONE : ratio_req;
        cnt_d   = ratio_d - ONE;
      end else begin
        cnt_d = cnt_q - ONE;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      ratio_q <= ONE;
    end else if (tick_in) begin
      cnt_q   <= cnt_d;
      ratio_q <= ratio_d;
    end
  end

  assign cnt_out   = cnt_q;
  assign ratio_out = ratio_q;
endmodule

// File: rtl/tim_doubler.sv
module tim_doubler #(
  parameter int RW = 5
) (
  input  logic          parent_tick,
  input  logic          bus_en,
  input  logic [RW-1:0] bus_cnt,
  input  logic [RW-1:0] bus_ratio,
  output logic          tim_en
);
  logic          pass_through;
  logic          at_half;
  logic [RW-1:0] half;

  assign half         = bus_ratio >> 1;
  assign pass_through = (bus_ratio == RW'(1));
  assign at_half      = (bus_cnt == '0) | (bus_cnt == half);

  always_comb begin
    if (pass_through) tim_en = bus_en;
    else              tim_en = parent_tick & at_half;
  end
endmodule

// File: rtl/fixed_ce.sv
module fixed_ce #(
  parameter int DIV = 8,
  localparam int CW = (DIV > 2) ? $clog2(DIV) : 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_in,
  output logic en_out
);
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          wrap;

  assign wrap   = (cnt_q == LAST);
  assign en_out = tick_in & wrap;

  always_comb begin
    cnt_d = cnt_q;
    if (tick_in) cnt_d = wrap ? '0 : cnt_q + CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt_q <= '0;
    else if (tick_in) cnt_q <= cnt_d;
  end
endmodule

// File: rtl/busclk_en_tree.sv
module busclk_en_tree
  import busclk_pkg::*;
#(
  parameter int AHB_CW   = 4,
  parameter int APB_CW   = 3,
  parameter int ADC_CW   = 2,
  parameter int TICK_DIV = 8,
  parameter int SD_DIV   = 2,
  localparam int AHB_RW  = (1 << (AHB_CW - 1)) + 2,
  localparam int APB_RW  = (1 << (APB_CW - 1)) + 1,
  localparam int ADC_RW  = $clog2(2 << ADC_CW) + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [AHB_CW-1:0] ahb_code,
  input  logic [APB_CW-1:0] apb_lo_code,
  input  logic [APB_CW-1:0] apb_hi_code,
  input  logic [ADC_CW-1:0] adc_code,
  output logic              en_ahb,
  output logic              en_apb_lo,
  output logic              en_apb_hi,
  output logic              en_tim_lo,
  output logic              en_tim_hi,
  output logic              en_adc,
  output logic              en_tick,
  output logic              en_sd,
  output logic [AHB_RW-1:0] ahb_div,
  output logic [APB_RW-1:0] apb_lo_div,
  output logic [APB_RW-1:0] apb_hi_div,
  output logic [ADC_RW-1:0] adc_div
);
  localparam int NUM_APB = 2;

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rs_q;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= '0;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_sync_n = rs_q[1];

  // system bus divider, ticking on every root cycle once running
  logic [AHB_RW-1:0] ahb_req;
  logic [AHB_RW-1:0] ahb_cnt;

  assign ahb_req = AHB_RW'(ahb_ratio_of(8'(ahb_code), AHB_CW));

  ce_divider #(.RW(AHB_RW)) u_ahb (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .tick_in   (rst_sync_n),
    .ratio_req (ahb_req),
    .en_out    (en_ahb),
    .cnt_out   (ahb_cnt),
    .ratio_out (ahb_div)
  );

  // peripheral buses and their timer kernels
  logic [APB_CW-1:0] apb_code_a  [NUM_APB];
  logic              apb_en_a    [NUM_APB];
  logic              tim_en_a    [NUM_APB];
  logic [APB_RW-1:0] apb_ratio_a [NUM_APB];

  assign apb_code_a[0] = apb_lo_code;
  assign apb_code_a[1] = apb_hi_code;

  for (genvar gi = 0; gi < NUM_APB; gi++) begin : g_apb
    logic [APB_RW-1:0] req;
    logic [APB_RW-1:0] cnt;

    assign req = APB_RW'(apb_ratio_of(8'(apb_code_a[gi]), APB_CW));

    ce_divider #(.RW(APB_RW)) u_div (
      .clk       (clk),
      .rst_n     (rst_sync_n),
      .tick_in   (en_ahb),
      .ratio_req (req),
      .en_out    (apb_en_a[gi]),
      .cnt_out   (cnt),
      .ratio_out (apb_ratio_a[gi])
    );

    tim_doubler #(.RW(APB_RW)) u_tim (
      .parent_tick (en_ahb),
      .bus_en      (apb_en_a[gi]),
      .bus_cnt     (cnt),
      .bus_ratio   (apb_ratio_a[gi]),
      .tim_en      (tim_en_a[gi])
    );
  end

  assign en_apb_lo  = apb_en_a[0];
  assign en_apb_hi  = apb_en_a[1];
  assign en_tim_lo  = tim_en_a[0];
  assign en_tim_hi  = tim_en_a[1];
  assign apb_lo_div = apb_ratio_a[0];
  assign apb_hi_div = apb_ratio_a[1];

  // ADC kernel under the high-speed peripheral bus
  logic [ADC_RW-1:0] adc_req;
  logic [ADC_RW-1:0] adc_cnt_unused;

  assign adc_req = ADC_RW'(adc_ratio_of(8'(adc_code)));

  ce_divider #(.RW(ADC_RW)) u_adc (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .tick_in   (apb_en_a[1]),
    .ratio_req (adc_req),
    .en_out    (en_adc),
    .cnt_out   (adc_cnt_unused),
    .ratio_out (adc_div)
  );

  // fixed taps off the system bus
  fixed_ce #(.DIV(TICK_DIV)) u_tick (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .tick_in (en_ahb),
    .en_out  (en_tick)
  );

  fixed_ce #(.DIV(SD_DIV)) u_sd (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .tick_in (en_ahb),
    .en_out  (en_sd)
  );
endmodule

// File: rtl/busclk_en_tree_chk.sv
module busclk_en_tree_chk #(
  parameter int AHB_RW = 10,
  parameter int APB_RW = 5,
  localparam int GW    = AHB_RW + 1
) (
  input logic              clk,
  input logic              rst_ok,
  input logic              en_ahb,
  input logic              en_apb_lo,
  input logic              en_apb_hi,
  input logic              en_tim_lo,
  input logic              en_tim_hi,
  input logic              en_adc,
  input logic              en_tick,
  input logic              en_sd,
  input logic [AHB_RW-1:0] ahb_div,
  input logic [APB_RW-1:0] apb_lo_div,
  input logic [APB_RW-1:0] apb_hi_div
);
  logic [GW-1:0] gap_q;
  logic          seen_q;

  always_ff @(posedge clk or negedge rst_ok) begin
    if (!rst_ok) begin
      gap_q  <= '0;
      seen_q <= 1'b0;
    end else begin
      if (en_ahb)            gap_q <= GW'(1);
      else if (gap_q != '1)  gap_q <= gap_q + GW'(1);
      if (en_ahb) seen_q <= 1'b1;
    end
  end

  a_r7_ahb_hold: assert property (@(posedge clk) disable iff (!rst_ok)
    (ahb_div == AHB_RW'(1)) |-> en_ahb);

  a_r8_apb_lo_nested: assert property (@(posedge clk) disable iff (!rst_ok)
    en_apb_lo |-> en_ahb);

  a_r8_apb_hi_nested: assert property (@(posedge clk) disable iff (!rst_ok)
    en_apb_hi |-> en_ahb);

  a_r8_ahb_single: assert property (@(posedge clk) disable iff (!rst_ok)
    en_ahb |=> (ahb_div == AHB_RW'(1) || !en_ahb));

  a_r3_tim_lo_covers: assert property (@(posedge clk) disable iff (!rst_ok)
    en_apb_lo |-> (en_tim_lo && en_ahb));

  a_r3_tim_hi_covers: assert property (@(posedge clk) disable iff (!rst_ok)
    en_apb_hi |-> (en_tim_hi && en_ahb));

  a_r3_tim_in_ahb: assert property (@(posedge clk) disable iff (!rst_ok)
    (en_tim_lo || en_tim_hi) |-> en_ahb);

  a_r4_adc_nested: assert property (@(posedge clk) disable iff (!rst_ok)
    en_adc |-> en_apb_hi);

  a_r5_tick_nested: assert property (@(posedge clk) disable iff (!rst_ok)
    en_tick |-> en_ahb);

  a_r6_sd_nested: assert property (@(posedge clk) disable iff (!rst_ok)
    en_sd |-> en_ahb);

  a_r9_ahb_div_stable: assert property (@(posedge clk) disable iff (!rst_ok)
    !en_ahb |=> $stable(ahb_div));

  a_r9_apb_lo_stable: assert property (@(posedge clk) disable iff (!rst_ok)
    !en_apb_lo |=> $stable(apb_lo_div));

  a_r9_apb_hi_stable: assert property (@(posedge clk) disable iff (!rst_ok)
    !en_apb_hi |=> $stable(apb_hi_div));

  a_r9_ahb_gap: assert property (@(posedge clk) disable iff (!rst_ok)
    (en_ahb && seen_q) |-> (gap_q == {1'b0, ahb_div}));
endmodule

bind busclk_en_tree busclk_en_tree_chk #(.AHB_RW(AHB_RW), .APB_RW(APB_RW)) u_chk (
  .clk        (clk),
  .rst_ok     (rst_sync_n),
  .en_ahb     (en_ahb),
  .en_apb_lo  (en_apb_lo),
  .en_apb_hi  (en_apb_hi),
  .en_tim_lo  (en_tim_lo),
  .en_tim_hi  (en_tim_hi),
  .en_adc     (en_adc),
  .en_tick    (en_tick),
  .en_sd      (en_sd),
  .ahb_div    (ahb_div),
  .apb_lo_div (apb_lo_div),
  .apb_hi_div (apb_hi_div)
);

// File: tb/busclk_en_tree_test.sv
`timescale 1ns/1ps
module busclk_en_tree_test;
  logic       clk;
  logic       rst_n;
  logic [3:0] ahb_code;
  logic [2:0] apb_lo_code, apb_hi_code;
  logic [1:0] adc_code;
  logic en_ahb, en_apb_lo, en_apb_hi, en_tim_lo, en_tim_hi, en_adc, en_tick, en_sd;
  logic [9:0] ahb_div;
  logic [4:0] apb_lo_div, apb_hi_div;
  logic [3:0] adc_div;

  int n_chk, n_bad;
  int c_ahb, c_alo, c_ahi, c_tlo, c_thi, c_adc, c_tick, c_sd;
  bit done;

  busclk_en_tree uut (
    .clk(clk), .rst_n(rst_n), .ahb_code(ahb_code), .apb_lo_code(apb_lo_code),
    .apb_hi_code(apb_hi_code), .adc_code(adc_code), .en_ahb(en_ahb),
    .en_apb_lo(en_apb_lo), .en_apb_hi(en_apb_hi), .en_tim_lo(en_tim_lo),
    .en_tim_hi(en_tim_hi), .en_adc(en_adc), .en_tick(en_tick), .en_sd(en_sd),
    .ahb_div(ahb_div), .apb_lo_div(apb_lo_div), .apb_hi_div(apb_hi_div),
    .adc_div(adc_div)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  function automatic int exp_ahb(input int code);
    if (code < 8) return 1;
    if (code < 12) return 1 << (code - 7);
    return 1 << (code - 6);
  endfunction

  function automatic int exp_apb(input int code);
    if (code < 4) return 1;
    return 1 << (code - 3);
  endfunction

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic settle();
    repeat (1200) @(negedge clk);
  endtask

  task automatic measure(input int w);
    c_ahb = 0; c_alo = 0; c_ahi = 0; c_tlo = 0; c_thi = 0;
    c_adc = 0; c_tick = 0; c_sd = 0;
    repeat (w) begin
      @(negedge clk);
      c_ahb += int'(en_ahb);   c_alo += int'(en_apb_lo); c_ahi += int'(en_apb_hi);
      c_tlo += int'(en_tim_lo); c_thi += int'(en_tim_hi); c_adc += int'(en_adc);
      c_tick += int'(en_tick); c_sd += int'(en_sd);
    end
  endtask

  task automatic set_codes(input int a, input int lo, input int hi, input int ad);
    @(negedge clk);
    ahb_code = 4'(a); apb_lo_code = 3'(lo); apb_hi_code = 3'(hi); adc_code = 2'(ad);
  endtask

  // R10: reset state and start-up
  task automatic t_reset();
    int k;
    rst_n = 1'b0;
    set_codes(11, 0, 0, 0);
    repeat (2) @(negedge clk);
    check("R10 strobes low in reset", int'({en_ahb, en_apb_lo, en_apb_hi, en_tim_lo,
          en_tim_hi, en_adc, en_tick, en_sd}), 0);
    check("R10 ahb_div in reset", int'(ahb_div), 1);
    check("R10 apb/adc div in reset", int'(apb_lo_div) + int'(apb_hi_div) + int'(adc_div), 3);
    rst_n = 1'b1;
    @(negedge clk);
    check("R10 no strobe one cycle after release", int'(en_ahb), 0);
    @(negedge clk);
    check("R10 first strobe two cycles after release", int'(en_ahb), 1);
    check("R10 ratio 1 before first strobe", int'(ahb_div), 1);
    k = 0;
    do begin @(negedge clk); k++; end while (!en_ahb && k < 2000);
    check("R10 first period uses configured code", k, 16);
    check("R10 ahb_div adopted", int'(ahb_div), 16);
  endtask

  // R1, R7: every AHB code
  task automatic t_ahb_codes();
    for (int c = 0; c < 16; c++) begin
      set_codes(c, 0, 0, 0);
      settle();
      measure(1024);
      check($sformatf("R1 en_ahb count code %0d", c), c_ahb, 1024 / exp_ahb(c));
      check($sformatf("R1 ahb_div code %0d", c), int'(ahb_div), exp_ahb(c));
      if (c == 3) check("R7 ratio-1 apb passes ahb", c_alo, 1024);
    end
  endtask

  // R2, R3: every APB code on both sides
  task automatic t_apb_codes();
    for (int c = 0; c < 8; c++) begin
      int r;
      r = exp_apb(c);
      set_codes(0, c, 7 - c, 0);
      settle();
      measure(512);
      check($sformatf("R2 apb_lo count code %0d", c), c_alo, 512 / r);
      check($sformatf("R2 apb_lo_div code %0d", c), int'(apb_lo_div), r);
      check($sformatf("R2 apb_hi count code %0d", 7 - c), c_ahi, 512 / exp_apb(7 - c));
      check($sformatf("R2 apb_hi_div code %0d", 7 - c), int'(apb_hi_div), exp_apb(7 - c));
      check($sformatf("R3 tim_lo count code %0d", c), c_tlo, (r == 1) ? 512 : 1024 / r);
      check($sformatf("R3 tim_hi count code %0d", 7 - c), c_thi,
            (exp_apb(7 - c) == 1) ? 512 : 1024 / exp_apb(7 - c));
    end
  endtask

  // R3 under a divided AHB
  task automatic t_tim_nested();
    set_codes(9, 4, 7, 0);
    settle();
    measure(512);
    check("R3 apb_lo at ahb/4 ratio 2", c_alo, 64);
    check("R3 tim_lo equals ahb rate", c_tlo, c_ahb);
    check("R3 tim_hi twice apb_hi", c_thi, 2 * c_ahi);
    check("R3 apb_hi at ahb/4 ratio 16", c_ahi, 8);
  endtask

  // R4: every ADC code
  task automatic t_adc();
    for (int c = 0; c < 4; c++) begin
      set_codes(0, 0, 0, c);
      settle();
      measure(240);
      check($sformatf("R4 adc count code %0d", c), c_adc, 240 / (2 * c + 2));
      check($sformatf("R4 adc_div code %0d", c), int'(adc_div), 2 * c + 2);
    end
    set_codes(8, 0, 4, 1);
    settle();
    measure(480);
    check("R4 adc under divided apb", c_adc, 480 / 16);
  endtask

  // R5, R6: fixed taps
  task automatic t_taps();
    set_codes(0, 0, 0, 0);
    settle();
    measure(512);
    check("R5 tick at root/8", c_tick, 64);
    check("R6 sd at root/2", c_sd, 256);
    set_codes(9, 0, 0, 0);
    settle();
    measure(512);
    check("R5 tick at ahb/8", c_tick, 16);
    check("R6 sd at ahb/2", c_sd, 64);
  endtask

  // R8: strobe widths
  task automatic t_width();
    int hi, rises;
    logic prev;
    set_codes(8, 4, 5, 0);
    settle();
    hi = 0; rises = 0; prev = 1'b0;
    repeat (256) begin
      @(negedge clk);
      hi += int'(en_ahb);
      if (en_ahb && !prev) rises++;
      prev = en_ahb;
    end
    check("R8 ahb strobe single cycle", hi, rises);
    check("R8 ahb strobe count", hi, 128);
  endtask

  // R9: change in mid period
  task automatic t_boundary();
    int k;
    set_codes(11, 0, 0, 0);
    settle();
    k = 0;
    do begin @(negedge clk); k++; end while (!en_ahb && k < 100);
    @(negedge clk);
    ahb_code = 4'd8;
    check("R9 div unchanged after code write", int'(ahb_div), 16);
    k = 1;
    do begin @(negedge clk); k++; end while (!en_ahb && k < 100);
    check("R9 old period kept", k, 16);
    check("R9 div still old at boundary", int'(ahb_div), 16);
    k = 0;
    do begin @(negedge clk); k++; end while (!en_ahb && k < 100);
    check("R9 new period after boundary", k, 2);
    check("R9 div updated", int'(ahb_div), 2);
    set_codes(15, 0, 0, 0);
    k = 0;
    do begin @(negedge clk); k++; end while (!en_ahb && k < 100);
    check("R9 short period finishes first", k <= 2 ? 1 : 0, 1);
    k = 0;
    do begin @(negedge clk); k++; end while (!en_ahb && k < 2000);
    check("R9 long ratio 512 applied", k, 512);
  endtask

  initial begin
    n_chk = 0; n_bad = 0; done = 1'b0;
    rst_n = 1'b0;
    ahb_code = '0; apb_lo_code = '0; apb_hi_code = '0; adc_code = '0;
    t_reset();
    t_ahb_codes();
    t_apb_codes();
    t_tim_nested();
    t_adc();
    t_taps();
    t_width();
    t_boundary();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog (all requirements): actual hung expected finished");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end
endmodule